// File: doc/BRIEF.md
# Serial Flash Data-Buffer Command Slave

This block is the serial front end of a page-organised flash device, reduced to its two SRAM data buffers. A host drives chip select, serial clock and serial data in. The block samples those pins with a faster system clock, assembles command bytes and answers on a serial data-out pin with a separate output enable. It decodes a one-byte opcode followed by a three-byte address. Those 24 address bits carry 15 don't-care bits and then a 9-bit byte address into one of two 264-byte buffers.

A host fills a buffer with a write command and streams its contents back with one of two read commands. One read command inserts a dummy byte before the data. The other sends data at once. The block also answers a status byte query and a manufacturer/device identity query. Any other opcode makes it deaf until chip select goes high again. A rising chip select ends any command at any bit position.

Top module: `sflash_buf_slave`

## Requirements
- R1: While reset is asserted, and after it is released with chip select high, `spi_miso_oe` is 0 and `spi_miso` is 0.
- R2: Opcode 84h writes buffer 0 and 87h writes buffer 1. Each data byte after the third address byte is stored at the current byte address, and the address then advances by one.
- R3: Opcodes D4h (buffer 0) and D6h (buffer 1) return buffer data after one dummy byte that follows the address. Opcodes D1h (buffer 0) and D3h (buffer 1) return data in the byte right after the address. Data bits go out MSB first and change after falling SCK edges. The host samples them on rising SCK edges.
- R4: Of the three address bytes, only bit 0 of the second byte (address bit 8) and the whole third byte (bits 7..0) matter. A 9-bit value above 263 is folded by subtracting 264.
- R5: During writes and reads, the byte address wraps from 263 to 0 inside the same buffer. The other buffer is never touched.
- R6: Opcode D7h returns the status byte A4h on every following byte: bit 7 ready=1, bits 5..2 = 1001, bits 6, 1 and 0 = 0.
- R7: Opcode 9Fh returns 1Fh, then 25h (family 001, density 00101), then 00h, then 00h (string length). Every later byte is 00h.
- R8: A rising chip select at any bit ends the command. `spi_miso_oe` falls within 4 system clocks. Bytes that were not completed are discarded, and the next command is decoded from a fresh bit count.
- R9: Any other opcode is ignored until chip select rises: `spi_miso_oe` stays 0 and neither buffer changes.
- R10: SPI modes 0 and 3 (SCK idling low or high) both work.
- R11: `spi_miso_oe` is 0 through the opcode, address and dummy bytes. It rises only after the last header byte completes, and `spi_miso` is 0 whenever `spi_miso_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Drive enable for `spi_miso` |

## Verification
Each serial pin passes two synchroniser stages and then one edge-detect register. A written byte therefore lands in its buffer, and a new output bit appears on `spi_miso`, three to four system clocks after the SCK edge at the pin. The enable drops three clocks after chip select rises. The bench moves SCK only every eight system clocks. It compares each received bit and the enable against its reference model just before the rising edge it drives, when the design's response has long settled. The idle enable is checked six clocks after chip select rises.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

  localparam logic [7:0] OP_WR_B0    = 8'h84;
  localparam logic [7:0] OP_WR_B1    = 8'h87;
  localparam logic [7:0] OP_RDD_B0   = 8'hD4;
  localparam logic [7:0] OP_RDD_B1   = 8'hD6;
  localparam logic [7:0] OP_RDF_B0   = 8'hD1;
  localparam logic [7:0] OP_RDF_B1   = 8'hD3;
  localparam logic [7:0] OP_STATUS   = 8'hD7;
  localparam logic [7:0] OP_IDENT    = 8'h9F;

  localparam int IDENT_LAST = 4;

  typedef enum logic [2:0] {
    K_NONE, K_WRITE, K_RD_DUMMY, K_RD_DIRECT, K_STATUS, K_IDENT
  } op_kind_e;

  typedef enum logic [2:0] {
    ST_OPC, ST_ADDR, ST_DUMMY, ST_WDATA, ST_RDATA, ST_STAT, ST_ID, ST_IGNORE
  } ctrl_state_e;

  function automatic op_kind_e op_kind(input logic [7:0] op);
    case (op)
      OP_WR_B0, OP_WR_B1:   return K_WRITE;
      OP_RDD_B0, OP_RDD_B1: return K_RD_DUMMY;
      OP_RDF_B0, OP_RDF_B1: return K_RD_DIRECT;
      OP_STATUS:            return K_STATUS;
      OP_IDENT:             return K_IDENT;
      default:              return K_NONE;
    endcase
  endfunction

  // Which buffer an opcode targets: 1 for the second buffer.
  function automatic logic op_buf(input logic [7:0] op);
    return (op == OP_WR_B1) || (op == OP_RDD_B1) || (op == OP_RDF_B1);
  endfunction

  // Fold a 9-bit byte address into the buffer range.
  function automatic int fold_addr(input int a, input int depth);
    return (a >= depth) ? a - depth : a;
  endfunction

  // Advance a byte address with wrap to zero at the buffer end.
  function automatic int step_addr(input int a, input int depth);
    return (a >= depth - 1) ? 0 : a + 1;
  endfunction

  function automatic logic [7:0] status_byte();
    logic       ready;
    logic [3:0] density;
    ready   = 1'b1;
    density = 4'b1001;
    return {ready, 1'b0, density, 1'b0, 1'b0};
  endfunction

  function automatic logic [7:0] ident_byte(input int idx);
    case (idx)
      0:       return 8'h1F;
      1:       return {3'b001, 5'b00101};
      2:       return {3'b000, 5'b00000};
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/sfb_pin_sync.sv
module sfb_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_pin,
  input  logic sck_pin,
  input  logic mosi_pin,
  output logic cs_idle,
  output logic mosi_s,
  output logic sck_rise,
  output logic sck_fall
);
  logic [STAGES-1:0] cs_pipe;
  logic [STAGES-1:0] sck_pipe;
  logic [STAGES-1:0] mosi_pipe;
  logic              sck_prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cs_pipe   <= '1;
          sck_pipe  <= '0;
          mosi_pipe <= '0;
        end else begin
          cs_pipe   <= cs_n_pin;
          sck_pipe  <= sck_pin;
          mosi_pipe <= mosi_pin;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cs_pipe   <= '1;
          sck_pipe  <= '0;
          mosi_pipe <= '0;
        end else begin
          cs_pipe   <= {cs_pipe[STAGES-2:0], cs_n_pin};
          sck_pipe  <= {sck_pipe[STAGES-2:0], sck_pin};
          mosi_pipe <= {mosi_pipe[STAGES-2:0], mosi_pin};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= sck_pipe[STAGES-1];
  end

  assign cs_idle  = cs_pipe[STAGES-1];
  assign mosi_s   = mosi_pipe[STAGES-1];
  assign sck_rise = sck_pipe[STAGES-1] & ~sck_prev;
  assign sck_fall = ~sck_pipe[STAGES-1] & sck_prev;
endmodule

// File: rtl/sfb_byte_rx.sv
module sfb_byte_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_idle,
  input  logic       sck_rise,
  input  logic       mosi_s,
  output logic       byte_done,
  output logic [7:0] byte_val
);
  logic [2:0] bit_cnt;
  logic [6:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (cs_idle) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (sck_rise) begin
      bit_cnt <= bit_cnt + 3'd1;
      shreg   <= {shreg[5:0], mosi_s};
    end
  end

  assign byte_done = sck_rise && !cs_idle && (bit_cnt == 3'd7);
  assign byte_val  = {shreg, mosi_s};
endmodule

// File: rtl/sfb_buf_mem.sv
module sfb_buf_mem #(
  parameter int DEPTH = 264,
  parameter int NBUF  = 2,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          rd_sel,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] rd_word [NBUF];

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    logic [7:0] mem [DEPTH];
    logic       hit;
    assign hit = wr_en && (int'(wr_sel) == g) && (int'(wr_addr) < DEPTH);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (hit) begin
        mem[wr_addr] <= wr_data;
      end
    end

    assign rd_word[g] = (int'(rd_addr) < DEPTH) ? mem[rd_addr] : 8'h00;
  end

  assign rd_data = rd_word[rd_sel];
endmodule

// File: rtl/sfb_cmd_ctrl.sv
module sfb_cmd_ctrl
  import sfb_pkg::*;
#(
  parameter int DEPTH = 264,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_idle,
  input  logic          byte_done,
  input  logic [7:0]    byte_val,
  input  logic [7:0]    rd_data,
  output logic          wr_en,
  output logic          wr_sel,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          rd_sel,
  output logic [AW-1:0] rd_addr,
  output logic          tx_load,
  output logic [7:0]    tx_byte,
  output logic          resp_on,
  output logic          in_ignore
);
  ctrl_state_e   st;
  logic [7:0]    op_q;
  logic [1:0]    hdr_cnt;
  logic          addr_msb;
  logic [AW-1:0] cur_addr;
  logic [2:0]    id_idx;
  logic          resp_q;
  op_kind_e      kind_q;
  op_kind_e      kind_new;
  logic [AW-1:0] start_addr;
  logic          live;
  logic          hdr_last;

  assign kind_q     = op_kind(op_q);
  assign kind_new   = op_kind(byte_val);
  assign live       = byte_done && !cs_idle;
  assign hdr_last   = (st == ST_ADDR) && (hdr_cnt == 2'd2);
  assign start_addr = AW'(fold_addr(int'({addr_msb, byte_val}), DEPTH));

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a);
    return AW'(step_addr(int'(a), DEPTH));
  endfunction

  always_comb begin
    wr_en   = 1'b0;
    tx_load = 1'b0;
    tx_byte = 8'h00;
    case (st)
      ST_OPC: begin
        if (live && kind_new == K_STATUS) begin
          tx_load = 1'b1;
          tx_byte = status_byte();
        end else if (live && kind_new == K_IDENT) begin
          tx_load = 1'b1;
          tx_byte = ident_byte(0);
        end
      end
      ST_ADDR: begin
        if (live && hdr_last && kind_q == K_RD_DIRECT) begin
          tx_load = 1'b1;
          tx_byte = rd_data;
        end
      end
      ST_DUMMY, ST_RDATA: begin
        if (live) begin
          tx_load = 1'b1;
          tx_byte = rd_data;
        end
      end
      ST_WDATA: wr_en = live;
      ST_STAT: begin
        if (live) begin
          tx_load = 1'b1;
          tx_byte = status_byte();
        end
      end
      ST_ID: begin
        if (live) begin
          tx_load = 1'b1;
          tx_byte = ident_byte(int'(id_idx));
        end
      end
      default: ;
    endcase
  end

  assign rd_addr   = (st == ST_ADDR) ? start_addr : cur_addr;
  assign rd_sel    = op_buf(op_q);
  assign wr_sel    = op_buf(op_q);
  assign wr_addr   = cur_addr;
  assign wr_data   = byte_val;
  assign resp_on   = resp_q;
  assign in_ignore = (st == ST_IGNORE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_OPC;
      op_q     <= '0;
      hdr_cnt  <= '0;
      addr_msb <= 1'b0;
      cur_addr <= '0;
      id_idx   <= '0;
      resp_q   <= 1'b0;
    end else if (cs_idle) begin
      st       <= ST_OPC;
      hdr_cnt  <= '0;
      id_idx   <= '0;
      resp_q   <= 1'b0;
    end else begin
      if (tx_load) resp_q <= 1'b1;
      if (byte_done) begin
        case (st)
          ST_OPC: begin
            op_q    <= byte_val;
            hdr_cnt <= '0;
            case (kind_new)
              K_WRITE, K_RD_DUMMY, K_RD_DIRECT: st <= ST_ADDR;
              K_STATUS: st <= ST_STAT;
              K_IDENT: begin
                st     <= ST_ID;
                id_idx <= 3'd1;
              end
              default: st <= ST_IGNORE;
            endcase
          end
          ST_ADDR: begin
            hdr_cnt <= hdr_cnt + 2'd1;
            if (hdr_cnt == 2'd1) addr_msb <= byte_val[0];
            if (hdr_cnt == 2'd2) begin
              case (kind_q)
                K_WRITE: begin
                  cur_addr <= start_addr;
                  st       <= ST_WDATA;
                end
                K_RD_DUMMY: begin
                  cur_addr <= start_addr;
                  st       <= ST_DUMMY;
                end
                default: begin
                  cur_addr <= nxt(start_addr);
                  st       <= ST_RDATA;
                end
              endcase
            end
          end
          ST_DUMMY: begin
            cur_addr <= nxt(cur_addr);
            st       <= ST_RDATA;
          end
          ST_WDATA, ST_RDATA: cur_addr <= nxt(cur_addr);
          ST_ID: if (int'(id_idx) < IDENT_LAST) id_idx <= id_idx + 3'd1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sfb_tx_shift.sv
module sfb_tx_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_idle,
  input  logic       sck_fall,
  input  logic       load,
  input  logic [7:0] load_byte,
  output logic       tx_bit
);
  logic [7:0] shreg;
  logic       hold_first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      hold_first <= 1'b0;
    end else if (cs_idle) begin
      shreg      <= '0;
      hold_first <= 1'b0;
    end else if (load) begin
      shreg      <= load_byte;
      hold_first <= 1'b1;
    end else if (sck_fall) begin
      if (hold_first) hold_first <= 1'b0;
      else            shreg      <= {shreg[6:0], 1'b0};
    end
  end

  assign tx_bit = shreg[7];
endmodule

// File: rtl/sflash_buf_slave.sv
module sflash_buf_slave #(
  parameter int BUF_DEPTH   = 264,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);
  localparam int AW   = $clog2(BUF_DEPTH);
  localparam int NBUF = 2;

  logic          cs_idle;
  logic          mosi_s;
  logic          sck_rise;
  logic          sck_fall;
  logic          byte_done;
  logic [7:0]    byte_val;
  logic          wr_en;
  logic          wr_sel;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          rd_sel;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          tx_load;
  logic [7:0]    tx_byte;
  logic          tx_bit;
  logic          resp_on;
  logic          in_ignore;

  sfb_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .cs_n_pin(spi_cs_n), .sck_pin(spi_sck), .mosi_pin(spi_mosi),
    .cs_idle(cs_idle), .mosi_s(mosi_s),
    .sck_rise(sck_rise), .sck_fall(sck_fall)
  );

  sfb_byte_rx u_rx (
    .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .sck_rise(sck_rise),
    .mosi_s(mosi_s), .byte_done(byte_done), .byte_val(byte_val)
  );

  sfb_cmd_ctrl #(.DEPTH(BUF_DEPTH), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle),
    .byte_done(byte_done), .byte_val(byte_val), .rd_data(rd_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_addr(rd_addr),
    .tx_load(tx_load), .tx_byte(tx_byte),
    .resp_on(resp_on), .in_ignore(in_ignore)
  );

  sfb_buf_mem #(.DEPTH(BUF_DEPTH), .NBUF(NBUF), .AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  sfb_tx_shift u_tx (
    .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .sck_fall(sck_fall),
    .load(tx_load), .load_byte(tx_byte), .tx_bit(tx_bit)
  );

  assign spi_miso_oe = resp_on;
  assign spi_miso    = resp_on & tx_bit;
endmodule

// File: rtl/sfb_checker.sv
module sfb_checker #(
  parameter int DEPTH = 264,
  parameter int AW    = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_idle,
  input logic          byte_done,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] rd_addr,
  input logic          tx_load,
  input logic          in_ignore,
  input logic          spi_miso,
  input logic          spi_miso_oe
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!spi_miso_oe && !spi_miso));

  assert_write_needs_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !cs_idle);

  assert_read_addr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> (int'(rd_addr) < DEPTH));

  assert_write_addr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < DEPTH));

  assert_oe_off_after_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> !spi_miso_oe);

  assert_ignore_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ignore |-> (!wr_en && !tx_load && !spi_miso_oe));

  assert_oe_rises_on_byte_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_miso_oe) |-> $past(byte_done));

  assert_miso_low_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_miso_oe |-> !spi_miso);
endmodule

bind sflash_buf_slave sfb_checker #(.DEPTH(BUF_DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .byte_done(byte_done),
  .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr), .tx_load(tx_load),
  .in_ignore(in_ignore), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe)
);

// File: tb/tb_sflash_buf_slave.sv
`timescale 1ns/1ps
module tb_sflash_buf_slave;
  localparam int HALF  = 8;
  localparam int DEPTH = 264;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso;
  logic miso_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [7:0] mdl [2][DEPTH];
  logic [7:0] wq[$];

  always #4 clk = ~clk;

  sflash_buf_slave dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
    .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int fold(input int a);
    return a % DEPTH;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_txn(input bit m3);
    wait_clk(1);
    sck = m3;
    wait_clk(HALF);
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic end_txn(input bit m3, input string req);
    wait_clk(HALF);
    if (!m3) sck = 1'b0;
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(6);
    check(req, "oe after select release", int'(miso_oe), 0);
    check(req, "data pin after select release", int'(miso), 0);
    wait_clk(HALF);
  endtask

  // One byte: falling edge, drive data, wait, sample, rising edge.
  task automatic xfer(input logic [7:0] tx, input bit resp, input logic [7:0] expb,
                      input string req);
    logic [7:0] got;
    int oe_bad;
    got = '0;
    oe_bad = 0;
    for (int i = 7; i >= 0; i--) begin
      wait_clk(1);
      sck = 1'b0;
      mosi = tx[i];
      wait_clk(HALF);
      got[i] = miso;
      if (miso_oe !== resp) oe_bad++;
      sck = 1'b1;
      wait_clk(HALF - 1);
    end
    check(req, resp ? "oe high in response" : "oe low in header", oe_bad, 0);
    if (resp) check(req, "response byte", int'(got), int'(expb));
  endtask

  task automatic xfer_bits(input int n, input logic [7:0] tx);
    for (int i = 7; i > 7 - n; i--) begin
      wait_clk(1);
      sck = 1'b0;
      mosi = tx[i];
      wait_clk(HALF);
      sck = 1'b1;
      wait_clk(HALF - 1);
    end
  endtask

  task automatic send_addr(input int a9, input logic [7:0] dc, input string req);
    xfer(dc, 1'b0, 8'h00, req);
    xfer({dc[7:1], a9[8]}, 1'b0, 8'h00, req);
    xfer(a9[7:0], 1'b0, 8'h00, req);
  endtask

  // Writes every byte in wq starting at address a9 into buffer b.
  task automatic do_write(input bit m3, input int b, input int a9, input logic [7:0] dc,
                          input string req);
    int a;
    begin_txn(m3);
    xfer(b ? 8'h87 : 8'h84, 1'b0, 8'h00, req);
    send_addr(a9, dc, req);
    a = fold(a9);
    foreach (wq[k]) begin
      xfer(wq[k], 1'b0, 8'h00, req);
      mdl[b][a] = wq[k];
      a = (a + 1) % DEPTH;
    end
    end_txn(m3, req);
  endtask

  task automatic do_read(input bit m3, input int b, input bit dummy, input int a9,
                         input int n, input string req);
    int a;
    logic [7:0] op;
    if (dummy) op = b ? 8'hD6 : 8'hD4;
    else       op = b ? 8'hD3 : 8'hD1;
    begin_txn(m3);
    xfer(op, 1'b0, 8'h00, req);
    send_addr(a9, 8'h00, req);
    if (dummy) xfer(8'hA5, 1'b0, 8'h00, req);
    a = fold(a9);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, 1'b1, mdl[b][a], req);
      a = (a + 1) % DEPTH;
    end
    end_txn(m3, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < DEPTH; i++) mdl[b][i] = 8'h00;

    // R1: outputs quiet in and after reset
    wait_clk(5);
    check("R1", "oe in reset", int'(miso_oe), 0);
    check("R1", "data in reset", int'(miso), 0);
    rst_n = 1'b1;
    wait_clk(10);
    check("R1", "oe after reset", int'(miso_oe), 0);

    // R2/R4: write buffer 0 at 10, read back with dummy byte (R3)
    wq = {8'h3C, 8'hA1, 8'h5E, 8'hFF, 8'h81};
    do_write(1'b0, 0, 10, 8'h00, "R2");
    do_read(1'b0, 0, 1'b1, 10, 6, "R3");

    // R5/R10: mode 3 write to buffer 1 across the end, direct read back
    wq = {8'h11, 8'h22, 8'h33, 8'h44};
    do_write(1'b1, 1, 262, 8'h00, "R10");
    do_read(1'b1, 1, 1'b0, 262, 5, "R5");
    do_read(1'b0, 1, 1'b1, 262, 4, "R10");

    // R5: buffer 0 untouched by the buffer 1 write
    do_read(1'b0, 0, 1'b0, 0, 3, "R5");

    // R4: don't-care bits set, address 300 folds to 36
    wq = {8'hC3, 8'h96};
    do_write(1'b0, 0, 300, 8'hFE, "R4");
    do_read(1'b1, 0, 1'b1, 36, 2, "R4");

    // R6: status byte repeats, both modes
    begin_txn(1'b0);
    xfer(8'hD7, 1'b0, 8'h00, "R6");
    for (int k = 0; k < 3; k++) xfer(8'h00, 1'b1, 8'hA4, "R6");
    end_txn(1'b0, "R6");
    begin_txn(1'b1);
    xfer(8'hD7, 1'b0, 8'h00, "R10");
    xfer(8'h00, 1'b1, 8'hA4, "R10");
    end_txn(1'b1, "R10");

    // R7: identity sequence then zeros
    begin_txn(1'b0);
    xfer(8'h9F, 1'b0, 8'h00, "R7");
    xfer(8'h00, 1'b1, 8'h1F, "R7");
    xfer(8'h00, 1'b1, 8'h25, "R7");
    xfer(8'h00, 1'b1, 8'h00, "R7");
    xfer(8'h00, 1'b1, 8'h00, "R7");
    xfer(8'h00, 1'b1, 8'h00, "R7");
    end_txn(1'b0, "R7");

    // R8: abort identity mid-byte, then a clean status read
    begin_txn(1'b0);
    xfer(8'h9F, 1'b0, 8'h00, "R8");
    xfer_bits(3, 8'h00);
    end_txn(1'b0, "R8");
    begin_txn(1'b0);
    xfer_bits(5, 8'hFF);
    end_txn(1'b0, "R8");
    begin_txn(1'b0);
    xfer(8'hD7, 1'b0, 8'h00, "R8");
    xfer(8'h00, 1'b1, 8'hA4, "R8");
    end_txn(1'b0, "R8");

    // R8: write aborted mid second byte keeps only the first
    begin_txn(1'b0);
    xfer(8'h87, 1'b0, 8'h00, "R8");
    send_addr(5, 8'h00, "R8");
    xfer(8'h6B, 1'b0, 8'h00, "R8");
    mdl[1][5] = 8'h6B;
    xfer_bits(4, 8'hF0);
    end_txn(1'b0, "R8");
    do_read(1'b0, 1, 1'b1, 5, 2, "R8");

    // R9: unsupported opcodes stay silent and change nothing
    begin_txn(1'b0);
    xfer(8'h55, 1'b0, 8'h00, "R9");
    xfer(8'h00, 1'b0, 8'h00, "R9");
    xfer(8'h00, 1'b0, 8'h00, "R9");
    xfer(8'h0A, 1'b0, 8'h00, "R9");
    xfer(8'h77, 1'b0, 8'h00, "R9");
    end_txn(1'b0, "R9");
    begin_txn(1'b0);
    xfer(8'h82, 1'b0, 8'h00, "R9");
    send_addr(10, 8'h00, "R9");
    xfer(8'hEE, 1'b0, 8'h00, "R9");
    xfer(8'hDD, 1'b0, 8'h00, "R9");
    end_txn(1'b0, "R9");
    do_read(1'b0, 0, 1'b1, 10, 2, "R9");

    // R11: header bytes keep oe low (checked in every xfer above)
    check("R11", "oe idle at end", int'(miso_oe), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule